// File: doc/BRIEF.md
# Triggered Burst Pulse Generator

This block turns a single trigger event into a fixed train of output pulses. When the trigger input rises and no burst is running, one up-counter starts and steps once per clock. A decode stage looks only at the counter value and drives the pulse line high on every even non-zero count. The result is a burst of equal one-cycle pulses separated by one-cycle gaps. A busy flag covers the whole burst.

The number of pulses is a parameter, `NUM_PULSES`, with a default of 5. The counter width is derived from it, so the default needs a 4-bit counter that runs from 1 up to 10. Start is taken from the rising edge of the trigger, found against a registered copy of it. A trigger that stays high therefore starts one burst only. A trigger that arrives while a burst is running is dropped.

Top module: `burst_pulse_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released with trig_i low, pulse_o and busy_o are both 0.
- R2: A rising edge of trig_i is a clock edge where trig_i is 1 and was 0 at the previous edge. When such an edge is seen while busy_o is 0, a burst starts and busy_o is 1 from the next cycle.
- R3: Every burst produces exactly NUM_PULSES pulses on pulse_o. The default is 5.
- R4: Each pulse is one clock cycle wide, and consecutive pulses are separated by exactly one low cycle.
- R5: Count the accepting edge as cycle 0. pulse_o is high in cycles 2, 4, … 2·NUM_PULSES and low in every other cycle of the burst.
- R6: busy_o stays high for 2·NUM_PULSES cycles and falls in the cycle right after the last pulse. The block then idles with pulse_o low until the next accepted rising edge.
- R7: A rising edge of trig_i while busy_o is 1 is ignored. It does not restart, extend or shorten the running burst.
- R8: Holding trig_i high for any number of cycles starts at most one burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger; a synchronous rising edge starts a burst |
| pulse_o | output | 1 | Burst pulse train |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
The counter is the only timing state, so any wrong count shows at the ports within one cycle. A skipped or repeated count shifts a pulse off its even slot, or merges two pulses into a two-cycle pulse. A missing wrap leaves busy_o stuck high after the tenth cycle. A lost or corrupted trigger copy shows as an extra burst, either from a held trigger or from a retrigger close to the end of a burst. The bench compares pulse_o and busy_o every cycle against a model built from the requirements, and it also counts the pulses in each finished burst.

// File: rtl/burst_pulse_pkg.sv
package burst_pulse_pkg;
  localparam int unsigned DEF_NUM_PULSES = 5;

  function automatic int unsigned last_count(input int unsigned n);
    return 2 * n;
  endfunction

  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(2 * n + 1);
  endfunction
endpackage

// File: rtl/burst_trig_edge.sv
module burst_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;

  // R8: a rise can never be reported on two consecutive edges
  a_r8_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned NUM_PULSES = burst_pulse_pkg::DEF_NUM_PULSES,
  parameter int unsigned CNT_W      = burst_pulse_pkg::count_width(NUM_PULSES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(burst_pulse_pkg::last_count(NUM_PULSES));

  logic [CNT_W-1:0] cnt_q;
  logic             idle;

  assign idle = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (idle) begin
      if (start_i)          cnt_q <= CNT_W'(1);
    end
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R7: a running burst always advances by one, whatever the trigger does
  a_r7_steady_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R6: the burst ends by returning to idle
  a_r6_wrap_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> cnt_q == '0);
  // R6: the counter stays within its range
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/burst_decode.sv
module burst_decode #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pulse_o,
  output logic             busy_o
);
  always_comb begin
    if (cnt_i == '0)     pulse_o = 1'b0;
    else if (cnt_i[0])   pulse_o = 1'b0;
    else                 pulse_o = 1'b1;
  end

  assign busy_o = (cnt_i != '0);

  // R4: one-cycle pulses
  a_r4_one_cycle_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  // R5: no pulse outside a burst
  a_r5_pulse_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
  parameter int unsigned NUM_PULSES = burst_pulse_pkg::DEF_NUM_PULSES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = burst_pulse_pkg::count_width(NUM_PULSES);

  logic             rise;
  logic [CNT_W-1:0] cnt;

  burst_trig_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  burst_counter #(.NUM_PULSES(NUM_PULSES), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rise),
    .cnt_o   (cnt)
  );

  burst_decode #(.CNT_W(CNT_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .pulse_o (pulse_o),
    .busy_o  (busy_o)
  );

  // R2: an accepted rise raises busy on the next cycle
  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !busy_o) |=> busy_o && !pulse_o);
  // R5: the first pulse follows the start cycle
  a_r5_first_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o)) |=> pulse_o);
endmodule

// File: tb/burst_pulse_gen_tb_top.sv
module burst_pulse_gen_tb_top;
  localparam int unsigned N    = 5;
  localparam int unsigned LAST = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic pulse, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_pulse_gen #(.NUM_PULSES(N)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .trig_i  (trig),
    .pulse_o (pulse),
    .busy_o  (busy)
  );

  // reference model built from R2..R8
  int  m_phase = 0;
  bit  m_trig_prev = 1'b0;
  int  pulses_seen = 0;
  int  high_run = 0;
  bit  prev_busy = 1'b0;

  function automatic bit exp_pulse(input int ph);
    return (ph != 0) && (ph % 2 == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      m_trig_prev = 1'b0;
    end else begin
      if (m_phase == 0) begin
        if (trig && !m_trig_prev) m_phase = 1;
      end else if (m_phase == LAST) m_phase = 0;
      else m_phase = m_phase + 1;
      m_trig_prev = trig;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pulse == exp_pulse(m_phase), "R5 pulse slot", pulse, exp_pulse(m_phase));
      check(busy == (m_phase != 0), "R2/R6 busy", busy, m_phase != 0);
      if (pulse) begin
        pulses_seen++;
        high_run++;
        check(high_run == 1, "R4 pulse width", high_run, 1);
      end else high_run = 0;
      if (prev_busy && !busy) begin
        check(pulses_seen == N, "R3 pulses per burst", pulses_seen, N);
        pulses_seen = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int burst_starts;
    void'($urandom(32'd1234));
    wait_cycles(3);
    check(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    wait_cycles(1);
    check(pulse == 1'b0 && busy == 1'b0, "R1 idle after reset", {pulse, busy}, 0);

    // R2/R5: single short trigger, exact timing
    trig = 1'b1; wait_cycles(1); trig = 1'b0;
    check(busy == 1'b1 && pulse == 1'b0, "R2 busy next cycle", {busy, pulse}, 2);
    wait_cycles(1);
    check(pulse == 1'b1, "R5 first pulse in cycle 2", pulse, 1);
    wait_cycles(LAST);
    check(busy == 1'b0, "R6 idle after burst", busy, 0);

    // R8: trigger held high for long
    burst_starts = 0;
    trig = 1'b1;
    for (int i = 0; i < 4 * LAST; i++) begin
      wait_cycles(1);
      if (busy && !prev_busy) burst_starts++;
    end
    trig = 1'b0;
    check(busy == 1'b0, "R8 held trigger one burst", busy, 0);
    wait_cycles(3);

    // R7: retrigger mid-burst and at the last pulse
    trig = 1'b1; wait_cycles(1); trig = 1'b0;
    wait_cycles(3);
    trig = 1'b1; wait_cycles(1); trig = 1'b0;
    wait_cycles(LAST - 6);
    trig = 1'b1; wait_cycles(1); trig = 1'b0;
    wait_cycles(1);
    check(busy == 1'b0, "R7 retrigger ignored", busy, 0);

    // R2: trigger right on the first idle cycle
    trig = 1'b1; wait_cycles(1); trig = 1'b0;
    check(busy == 1'b1, "R2 immediate restart", busy, 1);
    wait_cycles(LAST + 2);

    // random trigger pattern, checked every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      trig = ($urandom % 4) == 0;
      wait_cycles(1);
    end
    trig = 1'b0;
    wait_cycles(LAST + 3);
    check(busy == 1'b0 && pulse == 1'b0, "R6 final idle", {busy, pulse}, 0);
    finish_run();
  end

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule